// File: doc/BRIEF.md
# Acquisition Status Byte Controller

This block builds the read-only status byte that software polls in a data-acquisition front end. It follows four conditions. The first is a settling window that opens whenever the input channel or the gain/scan setting is rewritten. The second is a conversion-busy flag whose lifetime depends on whether scan mode is on. The third is a busy window for the digital-to-analog converter once an update is launched. The fourth is a latched FIFO overflow flag. The byte also reflects back the gain and scan setting last written, and it reports the single-ended/differential strap.

The surrounding logic feeds the block with register write strobes, a conversion start pulse, done pulses from the converter sequencer, a scan-complete pulse, and the FIFO's write, full and reset signals. The block returns the status byte. It also returns a FIFO write-accept qualifier, which blocks writes while an overflow is latched, and a pulse that marks a rejected DAC write. Window lengths are given in microseconds and converted to cycles from the clock frequency parameter.

Top module: `adc_status_ctrl`

## Requirements
- R1: The status byte is, from bit 7 down to bit 0: conversion busy, single-ended indicator, settling, DAC busy, overflow, scan enable, gain bit 1, gain bit 0. While reset is held with the strap at 1, the byte reads 0x40.
- R2: Bit 6 equals se_mode_i at all times. It reads 1 for single-ended and 0 for differential.
- R3: A gain write stores gain_wdata_i. Bit 2 of the data is scan enable and bits 1..0 are the gain. From the cycle after the write, status bits 2..0 show these values.
- R4: A channel or gain write sets bit 5 from the next cycle. Bit 5 then stays high for exactly CLK_FREQ_HZ/1e6*SETTLE_US cycles, which is 9 cycles at 1 MHz.
- R5: A channel or gain write while bit 5 is high restarts the full settling interval.
- R6: A write to the high DAC register while bit 4 is low sets bit 4 from the next cycle. Bit 4 then stays high for CLK_FREQ_HZ/1e6*DAC_US cycles, which is 30 cycles at 1 MHz. A write to the low DAC register does not start the window.
- R7: A DAC write of either register while bit 4 is high does not extend the window. In that same cycle, dac_drop_o is 1.
- R8: With scan enable at 0, a conversion start sets bit 7 from the next cycle and a conversion done clears it. If start and done arrive together, start wins.
- R9: With scan enable at 1, conversion done pulses do not clear bit 7. Only scan_done_i clears it.
- R10: A FIFO write while fifo_full_i is 1 sets bit 3 from the next cycle. Bit 3 then stays set until a FIFO reset.
- R11: fifo_wr_ok_o is 1 only when fifo_wr_i is 1, fifo_full_i is 0 and bit 3 is 0.
- R12: A FIFO reset clears bit 3 on the next cycle, and it wins over an overflow event in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chan_wr_i | input | 1 | Channel register write strobe |
| gain_wr_i | input | 1 | Gain/scan register write strobe |
| gain_wdata_i | input | 3 | Write data: bit 2 scan enable, bits 1..0 gain |
| dac_lo_wr_i | input | 1 | Low DAC register write strobe |
| dac_hi_wr_i | input | 1 | High DAC register write strobe, launches update |
| conv_start_i | input | 1 | Conversion start pulse |
| conv_done_i | input | 1 | Single conversion complete pulse |
| scan_done_i | input | 1 | Scan complete pulse |
| fifo_wr_i | input | 1 | Converter write request to FIFO |
| fifo_full_i | input | 1 | FIFO full flag |
| fifo_rst_i | input | 1 | FIFO reset |
| se_mode_i | input | 1 | Strap: 1 single-ended, 0 differential |
| status_o | output | 8 | Status byte |
| fifo_wr_ok_o | output | 1 | Qualified FIFO write |
| dac_drop_o | output | 1 | DAC write rejected while busy |

## Verification
Each status bit is driven by its own register, so a corrupted counter or flag shows up in the byte one cycle after the stimulus that should have set it. A timer that loads the wrong length or fails to reload shows as a settling or DAC window that is a cycle short or long. The bench therefore counts the high cycles of each window exactly. A mode error in the busy tracker appears on the first conversion done pulse inside a scan. A lost overflow latch appears on the cycle after the full-write, and it also shows on fifo_wr_ok_o.

// File: rtl/adc_stat_pkg.sv
package adc_stat_pkg;
  typedef struct packed {
    logic       busy;
    logic       se;
    logic       settle;
    logic       dac;
    logic       ovf;
    logic       scan;
    logic [1:0] gain;
  } stat_t;

  function automatic int unsigned us_to_cyc(int unsigned f_hz, int unsigned us);
    return (f_hz / 1_000_000) * us;
  endfunction
endpackage

// File: rtl/window_timer.sv
module window_timer #(
  parameter int unsigned CYCLES = 450,
  parameter bit          RETRIG = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic active_o,
  output logic hit_o
);
  localparam int unsigned W = $clog2(CYCLES + 1);

  logic [W-1:0] cnt_q;
  logic         load;

  assign active_o = (cnt_q != '0);
  assign hit_o    = trig_i & active_o;

  generate
    if (RETRIG) begin : g_retrig
      assign load = trig_i;
    end else begin : g_oneshot
      assign load = trig_i & ~active_o;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (load)     cnt_q <= W'(CYCLES);
    else if (active_o) cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/conv_busy.sv
module conv_busy (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scan_en_i,
  input  logic start_i,
  input  logic done_i,
  input  logic scan_done_i,
  output logic busy_o
);
  logic busy_q, end_ev;

  // in scan mode only the scan-complete pulse ends the busy period
  assign end_ev = scan_en_i ? scan_done_i : done_i;
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      busy_q <= 1'b0;
    else if (start_i) busy_q <= 1'b1;
    else if (end_ev)  busy_q <= 1'b0;
  end
endmodule

// File: rtl/ovf_latch.sv
module ovf_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic full_i,
  input  logic clr_i,
  output logic ovf_o,
  output logic wr_ok_o
);
  logic ovf_q;

  assign ovf_o   = ovf_q;
  assign wr_ok_o = wr_i & ~full_i & ~ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              ovf_q <= 1'b0;
    else if (clr_i)           ovf_q <= 1'b0;
    else if (wr_i && full_i)  ovf_q <= 1'b1;
  end
endmodule

// File: rtl/adc_status_ctrl.sv
module adc_status_ctrl
  import adc_stat_pkg::*;
#(
  parameter int unsigned CLK_FREQ_HZ = 50_000_000,
  parameter int unsigned SETTLE_US   = 9,
  parameter int unsigned DAC_US      = 30
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       chan_wr_i,
  input  logic       gain_wr_i,
  input  logic [2:0] gain_wdata_i,
  input  logic       dac_lo_wr_i,
  input  logic       dac_hi_wr_i,
  input  logic       conv_start_i,
  input  logic       conv_done_i,
  input  logic       scan_done_i,
  input  logic       fifo_wr_i,
  input  logic       fifo_full_i,
  input  logic       fifo_rst_i,
  input  logic       se_mode_i,
  output logic [7:0] status_o,
  output logic       fifo_wr_ok_o,
  output logic       dac_drop_o
);
  localparam int unsigned SETTLE_CYC = us_to_cyc(CLK_FREQ_HZ, SETTLE_US);
  localparam int unsigned DAC_CYC    = us_to_cyc(CLK_FREQ_HZ, DAC_US);

  logic [2:0] gain_q;
  logic       settle, dac_busy, dac_hit, busy, ovf, settle_hit;
  stat_t      st;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        gain_q <= '0;
    else if (gain_wr_i) gain_q <= gain_wdata_i;
  end

  window_timer #(.CYCLES(SETTLE_CYC), .RETRIG(1'b1)) u_settle (
    .clk_i, .rst_ni,
    .trig_i  (chan_wr_i | gain_wr_i),
    .active_o(settle),
    .hit_o   (settle_hit)
  );

  window_timer #(.CYCLES(DAC_CYC), .RETRIG(1'b0)) u_dac (
    .clk_i, .rst_ni,
    .trig_i  (dac_hi_wr_i),
    .active_o(dac_busy),
    .hit_o   (dac_hit)
  );

  conv_busy u_busy (
    .clk_i, .rst_ni,
    .scan_en_i  (gain_q[2]),
    .start_i    (conv_start_i),
    .done_i     (conv_done_i),
    .scan_done_i(scan_done_i),
    .busy_o     (busy)
  );

  ovf_latch u_ovf (
    .clk_i, .rst_ni,
    .wr_i   (fifo_wr_i),
    .full_i (fifo_full_i),
    .clr_i  (fifo_rst_i),
    .ovf_o  (ovf),
    .wr_ok_o(fifo_wr_ok_o)
  );

  // low-register writes are also rejected while an update is in flight
  assign dac_drop_o = dac_hit | (dac_lo_wr_i & dac_busy);

  always_comb begin
    st.busy   = busy;
    st.se     = se_mode_i;
    st.settle = settle;
    st.dac    = dac_busy;
    st.ovf    = ovf;
    st.scan   = gain_q[2];
    st.gain   = gain_q[1:0];
  end

  assign status_o = st;

  logic unused_hit;
  assign unused_hit = settle_hit;
endmodule

// File: rtl/adc_status_chk.sv
module adc_status_chk #(
  parameter int unsigned CLK_FREQ_HZ = 50_000_000,
  parameter int unsigned SETTLE_US   = 9
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       chan_wr_i,
  input logic       gain_wr_i,
  input logic [2:0] gain_wdata_i,
  input logic       dac_hi_wr_i,
  input logic       conv_start_i,
  input logic       fifo_wr_i,
  input logic       fifo_full_i,
  input logic       fifo_rst_i,
  input logic       se_mode_i,
  input logic [7:0] status_o,
  input logic       fifo_wr_ok_o
);
  localparam int unsigned SET_CYC = (CLK_FREQ_HZ / 1_000_000) * SETTLE_US;

  int unsigned since_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     since_q <= SET_CYC + 1;
    else if (chan_wr_i || gain_wr_i) since_q <= 1;
    else if (since_q <= SET_CYC)     since_q <= since_q + 1;
  end

  AST_SE_STRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[6] == se_mode_i); // R2
  AST_GAIN_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gain_wr_i |=> status_o[2:0] == $past(gain_wdata_i)); // R3
  AST_SETTLE_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chan_wr_i || gain_wr_i) |=> status_o[5]); // R5
  AST_SETTLE_EXPIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[5] |-> since_q <= SET_CYC); // R4
  AST_DAC_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dac_hi_wr_i && !status_o[4]) |=> status_o[4]); // R6
  AST_CONV_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_i |=> status_o[7]); // R8
  AST_OVF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_wr_i && fifo_full_i && !fifo_rst_i) |=> status_o[3]); // R10
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[3] && !fifo_rst_i) |=> status_o[3]); // R10
  AST_WR_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[3] || fifo_full_i) |-> !fifo_wr_ok_o); // R11
  AST_OVF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_rst_i |=> !status_o[3]); // R12
endmodule

bind adc_status_ctrl adc_status_chk #(
  .CLK_FREQ_HZ(CLK_FREQ_HZ),
  .SETTLE_US  (SETTLE_US)
) u_chk (
  .clk_i, .rst_ni, .chan_wr_i, .gain_wr_i, .gain_wdata_i, .dac_hi_wr_i,
  .conv_start_i, .fifo_wr_i, .fifo_full_i, .fifo_rst_i, .se_mode_i,
  .status_o, .fifo_wr_ok_o
);

// File: tb/sim_adc_status_ctrl.sv
`timescale 1ns/1ps
module sim_adc_status_ctrl;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       chan_wr = 0, gain_wr = 0, dac_lo = 0, dac_hi = 0;
  logic [2:0] gdata = '0;
  logic       cstart = 0, cdone = 0, sdone = 0, fwr = 0, ffull = 0, frst = 0, se = 1;
  logic [7:0] status;
  logic       wr_ok, drop;
  int         n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  adc_status_ctrl #(.CLK_FREQ_HZ(1_000_000), .SETTLE_US(9), .DAC_US(30)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .chan_wr_i(chan_wr), .gain_wr_i(gain_wr),
    .gain_wdata_i(gdata), .dac_lo_wr_i(dac_lo), .dac_hi_wr_i(dac_hi),
    .conv_start_i(cstart), .conv_done_i(cdone), .scan_done_i(sdone),
    .fifo_wr_i(fwr), .fifo_full_i(ffull), .fifo_rst_i(frst), .se_mode_i(se),
    .status_o(status), .fifo_wr_ok_o(wr_ok), .dac_drop_o(drop)
  );

  // [19] gain_wr [18:16] data [15] start [14] done [13] scan_done
  // [12] fifo_wr [11] full [10] fifo_rst [7:0] expected status, bits 7,3,2..0
  localparam int NV = 17;
  localparam logic [19:0] VEC [NV] = '{
    20'h9_00_01, 20'h0_80_81, 20'h0_00_81, 20'h0_40_01,
    20'hE_00_06, 20'h0_80_86, 20'h0_40_86, 20'h0_40_86,
    20'h0_20_06, 20'h0_10_06, 20'h0_18_0E, 20'h0_00_0E,
    20'h0_04_06, 20'h0_1C_06, 20'h8_00_00, 20'h0_C0_80,
    20'h0_40_00
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic idle();
    chan_wr = 0; gain_wr = 0; dac_lo = 0; dac_hi = 0; cstart = 0; cdone = 0;
    sdone = 0; fwr = 0; ffull = 0; frst = 0;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk); idle();
  endtask

  task automatic count_high(input int bitn, output int n);
    n = 0;
    while (status[bitn] && n < 200) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin : watchdog
    #1_000_000;
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int n;
    #20;
    @(negedge clk);
    check("R1 reset value", status, 8'h40);
    se = 0; #1;
    check("R2 differential strap", {7'd0, status[6]}, 8'd0);
    se = 1; #1;
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      gain_wr = VEC[i][19]; gdata = VEC[i][18:16];
      cstart = VEC[i][15]; cdone = VEC[i][14]; sdone = VEC[i][13];
      fwr = VEC[i][12]; ffull = VEC[i][11]; frst = VEC[i][10];
      step();
      check($sformatf("R3/R8/R9/R10/R12 vector %0d", i), status & 8'h8F, VEC[i][7:0]);
    end

    repeat (12) step();
    // R4 exact settle length
    chan_wr = 1; step();
    count_high(5, n);
    check("R4 settle length", 8'(n), 8'd9);
    // R5 retrigger
    chan_wr = 1; step();
    repeat (4) step();
    chan_wr = 1; step();
    count_high(5, n);
    check("R5 retrigger restart", 8'(n), 8'd9);
    // R6 low write does not start, high write starts
    dac_lo = 1; step();
    check("R6 low write no start", {7'd0, status[4]}, 8'd0);
    dac_hi = 1; step();
    count_high(4, n);
    check("R6 dac length", 8'(n), 8'd30);
    // R7 write while busy ignored
    dac_hi = 1; step();
    repeat (10) step();
    dac_hi = 1; #1;
    check("R7 drop flag", {7'd0, drop}, 8'd1);
    step();
    count_high(4, n);
    check("R7 no extension", 8'(n), 8'd19);
    // R11 write qualifier
    fwr = 1; #1;
    check("R11 accept", {7'd0, wr_ok}, 8'd1);
    ffull = 1; #1;
    check("R11 full blocks", {7'd0, wr_ok}, 8'd0);
    step();
    fwr = 1; #1;
    check("R11 ovf blocks", {7'd0, wr_ok}, 8'd0);
    idle();
    step();
    check("R10 sticky", {7'd0, status[3]}, 8'd1);
    frst = 1; step();
    check("R12 reset clears", {7'd0, status[3]}, 8'd0);
    se = 0; #1;
    check("R2 strap follows", {7'd0, status[6]}, 8'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule